// File: doc/BRIEF.md
# Vector Register Partial-Move Unit

This block holds a file of sixteen 128-bit vector registers and carries out partial data moves on them. Each request names an operation, a destination index, a source index and a 64-bit word of load data. Depending on the operation, the block moves 32-bit or 64-bit pieces between two registers, from the load word into a register, or from a register out on a store stream. Each operation has a fixed rule for the destination lanes it does not write. Some operations keep the old contents of those lanes. The scalar loads clear them to zero.

Requests use a valid/ready handshake. A request is taken on a rising edge when `req_valid` and `req_ready` are both high. Store results leave on a registered valid/ready stream one cycle after the request is taken. If the store output still holds a word that the consumer has not accepted, `req_ready` drops. Every request then waits, including those that do not store, so the ordering between stores and register updates is kept. The data at `st_data` stays fixed while `st_valid` is high and `st_ready` is low. A combinational debug port returns any whole register.

The 128-bit register is treated as four 32-bit lanes. Lane 0 is bits 31:0 and lane 3 is bits 127:96.

Top module: `vpm_unit`

## Requirements
- R1: A synchronous active-high reset clears every register to zero and drives `st_valid` low. After reset, `req_ready` is high.
- R2: Op 4'd1 (load high) writes `req_mem` into bits 127:64 of register `req_dst`. Bits 63:0 keep their old value.
- R3: Op 4'd3 (load low) writes `req_mem` into bits 63:0 of register `req_dst`. Bits 127:64 keep their old value.
- R4: Op 4'd5 (high to low) copies bits 127:64 of register `req_src` into bits 63:0 of `req_dst`. Bits 127:64 of `req_dst` keep their old value.
- R5: Op 4'd6 (low to high) copies bits 63:0 of `req_src` into bits 127:64 of `req_dst`. Bits 63:0 of `req_dst` keep their old value.
- R6: Op 4'd7 (scalar-32 move) copies bits 31:0 of `req_src` into bits 31:0 of `req_dst`. Bits 127:32 keep their old value.
- R7: Op 4'd8 (scalar-32 load) writes `req_mem[31:0]` into bits 31:0 of `req_dst` and clears bits 127:32 to zero.
- R8: Op 4'd10 (scalar-64 move) copies bits 63:0 of `req_src` into bits 63:0 of `req_dst` and keeps bits 127:64. Op 4'd11 (scalar-64 load) writes `req_mem` into bits 63:0 and clears bits 127:64.
- R9: The store ops place a word on `st_data` and raise `st_valid` in the cycle after the request is taken, with no register write. Op 4'd2 stores bits 127:64 of `req_src`. Ops 4'd4 and 4'd12 store bits 63:0. Op 4'd9 stores bits 31:0, zero-extended to 64 bits.
- R10: While `st_valid` is high and `st_ready` is low, `st_valid` and `st_data` hold their values and `req_ready` is low. A request offered in that state changes no register.
- R11: Op codes 4'd0, 4'd13, 4'd14 and 4'd15 write no register and produce no store. Taking any request that is not a store clears a store word that has been accepted.
- R12: When `req_src` equals `req_dst`, a register-to-register move reads the value the register held before the write.
- R13: `dbg_data` always shows the full contents of register `dbg_idx`. A write becomes visible there after the rising edge on which its request is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 4 | Operation code |
| req_dst | input | 4 | Destination register index |
| req_src | input | 4 | Source register index (register moves and stores) |
| req_mem | input | 64 | Load data word |
| st_valid | output | 1 | Store word present |
| st_ready | input | 1 | Consumer accepts store word |
| st_data | output | 64 | Store word |
| dbg_idx | input | 4 | Debug register select |
| dbg_data | output | 128 | Contents of the selected register |

## Verification
The bench sweeps all sixteen op codes over every destination register. Each destination is paired with a distinct source once and with itself once. After every request it compares the touched register and the store word against an arithmetic model. A design that mixed up the keep and clear rules would show stale upper bits after a scalar load, or lost upper bits after a scalar register move. A design that read the source after the write would give the wrong result when source and destination are the same register. A store that drops its word under back-pressure, or a request taken while the store output is blocked, shows up as a changed `st_data` or an unexpected register update.

// File: rtl/vpm_pkg.sv
package vpm_pkg;

  localparam int VEC_W   = 128;
  localparam int LANE_W  = 32;
  localparam int N_LANES = VEC_W / LANE_W;
  localparam int MEM_W   = 64;
  localparam int OP_W    = 4;

  localparam logic [OP_W-1:0] OP_LD_HI  = 4'd1;
  localparam logic [OP_W-1:0] OP_ST_HI  = 4'd2;
  localparam logic [OP_W-1:0] OP_LD_LO  = 4'd3;
  localparam logic [OP_W-1:0] OP_ST_LO  = 4'd4;
  localparam logic [OP_W-1:0] OP_MV_H2L = 4'd5;
  localparam logic [OP_W-1:0] OP_MV_L2H = 4'd6;
  localparam logic [OP_W-1:0] OP_MV_S32 = 4'd7;
  localparam logic [OP_W-1:0] OP_LD_S32 = 4'd8;
  localparam logic [OP_W-1:0] OP_ST_S32 = 4'd9;
  localparam logic [OP_W-1:0] OP_MV_S64 = 4'd10;
  localparam logic [OP_W-1:0] OP_LD_S64 = 4'd11;
  localparam logic [OP_W-1:0] OP_ST_S64 = 4'd12;

  typedef enum logic [1:0] {
    LANE_KEEP = 2'd0,
    LANE_ZERO = 2'd1,
    LANE_REG  = 2'd2,
    LANE_MEM  = 2'd3
  } lane_kind_e;

  typedef struct packed {
    lane_kind_e kind;
    logic [1:0] idx;
  } lane_sel_t;

endpackage

// File: rtl/vpm_regfile.sv
module vpm_regfile #(
  parameter int NREGS = 16,
  parameter int WIDTH = 128,
  localparam int IDXW = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDXW-1:0]  waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IDXW-1:0]  raddr_dst,
  input  logic [IDXW-1:0]  raddr_src,
  input  logic [IDXW-1:0]  raddr_dbg,
  output logic [WIDTH-1:0] rdata_dst,
  output logic [WIDTH-1:0] rdata_src,
  output logic [WIDTH-1:0] rdata_dbg
);

  logic [WIDTH-1:0] regs [NREGS];

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[i] <= '0;
      end else if (we && (waddr == IDXW'(i))) begin
        regs[i] <= wdata;
      end
    end
  end

  // Reads see the value held before this cycle's write.
  assign rdata_dst = regs[raddr_dst];
  assign rdata_src = regs[raddr_src];
  assign rdata_dbg = regs[raddr_dbg];

endmodule

// File: rtl/vpm_lane_plan.sv
module vpm_lane_plan
  import vpm_pkg::*;
(
  input  logic [OP_W-1:0]              op,
  output lane_sel_t [N_LANES-1:0]      plan,
  output logic                         write_en,
  output logic                         store_en,
  output logic [1:0]                   st_lo_lane,
  output logic [1:0]                   st_hi_lane,
  output logic                         st_hi_zero
);

  function automatic lane_sel_t sel(input lane_kind_e k, input logic [1:0] i);
    lane_sel_t s;
    s.kind = k;
    s.idx  = i;
    return s;
  endfunction

  always_comb begin
    for (int l = 0; l < N_LANES; l++) begin
      plan[l] = sel(LANE_KEEP, 2'd0);
    end
    write_en   = 1'b0;
    store_en   = 1'b0;
    st_lo_lane = 2'd0;
    st_hi_lane = 2'd1;
    st_hi_zero = 1'b0;

    unique case (op)
      OP_LD_HI: begin
        write_en = 1'b1;
        plan[2]  = sel(LANE_MEM, 2'd0);
        plan[3]  = sel(LANE_MEM, 2'd1);
      end
      OP_LD_LO: begin
        write_en = 1'b1;
        plan[0]  = sel(LANE_MEM, 2'd0);
        plan[1]  = sel(LANE_MEM, 2'd1);
      end
      OP_MV_H2L: begin
        write_en = 1'b1;
        plan[0]  = sel(LANE_REG, 2'd2);
        plan[1]  = sel(LANE_REG, 2'd3);
      end
      OP_MV_L2H: begin
        write_en = 1'b1;
        plan[2]  = sel(LANE_REG, 2'd0);
        plan[3]  = sel(LANE_REG, 2'd1);
      end
      OP_MV_S32: begin
        write_en = 1'b1;
        plan[0]  = sel(LANE_REG, 2'd0);
      end
      OP_LD_S32: begin
        write_en = 1'b1;
        plan[0]  = sel(LANE_MEM, 2'd0);
        plan[1]  = sel(LANE_ZERO, 2'd0);
        plan[2]  = sel(LANE_ZERO, 2'd0);
        plan[3]  = sel(LANE_ZERO, 2'd0);
      end
      OP_MV_S64: begin
        write_en = 1'b1;
        plan[0]  = sel(LANE_REG, 2'd0);
        plan[1]  = sel(LANE_REG, 2'd1);
      end
      OP_LD_S64: begin
        write_en = 1'b1;
        plan[0]  = sel(LANE_MEM, 2'd0);
        plan[1]  = sel(LANE_MEM, 2'd1);
        plan[2]  = sel(LANE_ZERO, 2'd0);
        plan[3]  = sel(LANE_ZERO, 2'd0);
      end
      OP_ST_HI: begin
        store_en   = 1'b1;
        st_lo_lane = 2'd2;
        st_hi_lane = 2'd3;
      end
      OP_ST_LO, OP_ST_S64: begin
        store_en   = 1'b1;
        st_lo_lane = 2'd0;
        st_hi_lane = 2'd1;
      end
      OP_ST_S32: begin
        store_en   = 1'b1;
        st_lo_lane = 2'd0;
        st_hi_zero = 1'b1;
      end
      default: begin
        write_en = 1'b0;
        store_en = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/vpm_lane_merge.sv
module vpm_lane_merge
  import vpm_pkg::*;
(
  input  lane_sel_t [N_LANES-1:0] plan,
  input  logic [VEC_W-1:0]        dst_old,
  input  logic [VEC_W-1:0]        src_old,
  input  logic [MEM_W-1:0]        mem,
  output logic [VEC_W-1:0]        merged
);

  localparam int LSB_W = $clog2(LANE_W);

  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    logic [LANE_W-1:0] lane_v;

    always_comb begin
      unique case (plan[l].kind)
        LANE_KEEP: lane_v = dst_old[l*LANE_W +: LANE_W];
        LANE_ZERO: lane_v = '0;
        LANE_REG:  lane_v = src_old[{plan[l].idx, {LSB_W{1'b0}}} +: LANE_W];
        LANE_MEM:  lane_v = mem[{plan[l].idx[0], {LSB_W{1'b0}}} +: LANE_W];
        default:   lane_v = dst_old[l*LANE_W +: LANE_W];
      endcase
    end

    assign merged[l*LANE_W +: LANE_W] = lane_v;
  end

endmodule

// File: rtl/vpm_store_stage.sv
module vpm_store_stage #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             load,
  input  logic [WIDTH-1:0] data_in,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take && load) begin
      out_valid <= 1'b1;
      out_data  <= data_in;
    end else if (take || out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/vpm_unit.sv
module vpm_unit
  import vpm_pkg::*;
#(
  parameter int NREGS = 16,
  localparam int IDXW = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [OP_W-1:0]   req_op,
  input  logic [IDXW-1:0]   req_dst,
  input  logic [IDXW-1:0]   req_src,
  input  logic [MEM_W-1:0]  req_mem,
  output logic              st_valid,
  input  logic              st_ready,
  output logic [MEM_W-1:0]  st_data,
  input  logic [IDXW-1:0]   dbg_idx,
  output logic [VEC_W-1:0]  dbg_data
);

  localparam int LSB_W = $clog2(LANE_W);

  logic                    fire;
  logic                    rf_we;
  logic [VEC_W-1:0]        rf_wdata;
  logic [VEC_W-1:0]        dst_old;
  logic [VEC_W-1:0]        src_old;
  lane_sel_t [N_LANES-1:0] plan;
  logic                    plan_we;
  logic                    plan_st;
  logic [1:0]              st_lo_lane;
  logic [1:0]              st_hi_lane;
  logic                    st_hi_zero;
  logic [MEM_W-1:0]        st_word;

  // A blocked store word holds back every request to keep ordering.
  assign req_ready = !st_valid || st_ready;
  assign fire      = req_valid && req_ready;

  vpm_lane_plan u_plan (
    .op         (req_op),
    .plan       (plan),
    .write_en   (plan_we),
    .store_en   (plan_st),
    .st_lo_lane (st_lo_lane),
    .st_hi_lane (st_hi_lane),
    .st_hi_zero (st_hi_zero)
  );

  vpm_regfile #(
    .NREGS (NREGS),
    .WIDTH (VEC_W)
  ) u_rf (
    .clk       (clk),
    .rst       (rst),
    .we        (rf_we),
    .waddr     (req_dst),
    .wdata     (rf_wdata),
    .raddr_dst (req_dst),
    .raddr_src (req_src),
    .raddr_dbg (dbg_idx),
    .rdata_dst (dst_old),
    .rdata_src (src_old),
    .rdata_dbg (dbg_data)
  );

  vpm_lane_merge u_merge (
    .plan    (plan),
    .dst_old (dst_old),
    .src_old (src_old),
    .mem     (req_mem),
    .merged  (rf_wdata)
  );

  assign rf_we = fire && plan_we;

  assign st_word[LANE_W-1:0] = src_old[{st_lo_lane, {LSB_W{1'b0}}} +: LANE_W];
  assign st_word[MEM_W-1:LANE_W] = st_hi_zero ? '0
                                 : src_old[{st_hi_lane, {LSB_W{1'b0}}} +: LANE_W];

  vpm_store_stage #(
    .WIDTH (MEM_W)
  ) u_store (
    .clk       (clk),
    .rst       (rst),
    .take      (fire),
    .load      (plan_st),
    .data_in   (st_word),
    .out_ready (st_ready),
    .out_valid (st_valid),
    .out_data  (st_data)
  );

endmodule

// File: rtl/vpm_unit_chk.sv
module vpm_unit_chk
  import vpm_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [OP_W-1:0]   req_op,
  input logic              st_valid,
  input logic              st_ready,
  input logic [MEM_W-1:0]  st_data,
  input logic              rf_we,
  input logic [VEC_W-1:0]  rf_wdata
);

  logic is_store;
  logic is_unused;
  logic taken;

  assign is_store  = (req_op == OP_ST_HI) || (req_op == OP_ST_LO) ||
                     (req_op == OP_ST_S32) || (req_op == OP_ST_S64);
  assign is_unused = (req_op == 4'd0) || (req_op > OP_ST_S64);
  assign taken     = req_valid && req_ready;

  p_store_next_r9: assert property (@(posedge clk) disable iff (rst)
    (taken && is_store) |=> st_valid);

  p_store_no_write_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && is_store) |-> !rf_we);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !st_ready) |=> (st_valid && $stable(st_data)));

  p_stall_r10: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !st_ready) |-> (!req_ready && !rf_we));

  p_unused_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && is_unused) |-> !rf_we);

  p_drain_r11: assert property (@(posedge clk) disable iff (rst)
    (taken && !is_store) |=> !st_valid);

  p_zero_s32_r7: assert property (@(posedge clk) disable iff (rst)
    (rf_we && (req_op == OP_LD_S32)) |-> (rf_wdata[VEC_W-1:LANE_W] == '0));

  p_zero_s64_r8: assert property (@(posedge clk) disable iff (rst)
    (rf_we && (req_op == OP_LD_S64)) |-> (rf_wdata[VEC_W-1:MEM_W] == '0));

endmodule

bind vpm_unit vpm_unit_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_op    (req_op),
  .st_valid  (st_valid),
  .st_ready  (st_ready),
  .st_data   (st_data),
  .rf_we     (rf_we),
  .rf_wdata  (rf_wdata)
);

// File: tb/test_vpm_unit.sv
module test_vpm_unit;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic         clk = 1'b0;
  logic         rst;
  logic         req_valid;
  logic         req_ready;
  logic [3:0]   req_op;
  logic [3:0]   req_dst;
  logic [3:0]   req_src;
  logic [63:0]  req_mem;
  logic         st_valid;
  logic         st_ready;
  logic [63:0]  st_data;
  logic [3:0]   dbg_idx;
  logic [127:0] dbg_data;

  int n_chk  = 0;
  int n_fail = 0;
  logic [127:0] model [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  vpm_unit i_vpm_unit (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .req_dst   (req_dst),
    .req_src   (req_src),
    .req_mem   (req_mem),
    .st_valid  (st_valid),
    .st_ready  (st_ready),
    .st_data   (st_data),
    .dbg_idx   (dbg_idx),
    .dbg_data  (dbg_data)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [3:0] op, input logic same);
    if (same && (op == 4'd5 || op == 4'd6 || op == 4'd7 || op == 4'd10)) return "R12";
    case (op)
      4'd1: return "R2";
      4'd3: return "R3";
      4'd5: return "R4";
      4'd6: return "R5";
      4'd7: return "R6";
      4'd8: return "R7";
      4'd10, 4'd11: return "R8";
      4'd2, 4'd4, 4'd9, 4'd12: return "R9";
      default: return "R11";
    endcase
  endfunction

  // Expected register contents after one operation, from the requirements.
  function automatic logic [127:0] exp_reg(input logic [3:0] op, input logic [127:0] d,
                                           input logic [127:0] s, input logic [63:0] m);
    case (op)
      4'd1:  return {m, d[63:0]};
      4'd3:  return {d[127:64], m};
      4'd5:  return {d[127:64], s[127:64]};
      4'd6:  return {s[63:0], d[63:0]};
      4'd7:  return {d[127:32], s[31:0]};
      4'd8:  return {96'd0, m[31:0]};
      4'd10: return {d[127:64], s[63:0]};
      4'd11: return {64'd0, m};
      default: return d;
    endcase
  endfunction

  function automatic logic exp_is_store(input logic [3:0] op);
    return (op == 4'd2) || (op == 4'd4) || (op == 4'd9) || (op == 4'd12);
  endfunction

  function automatic logic [63:0] exp_store(input logic [3:0] op, input logic [127:0] s);
    case (op)
      4'd2:    return s[127:64];
      4'd9:    return {32'd0, s[31:0]};
      default: return s[63:0];
    endcase
  endfunction

  task automatic do_op(input logic [3:0] op, input logic [3:0] dst,
                       input logic [3:0] src, input logic [63:0] mem);
    logic [127:0] nd;
    logic [63:0]  sd;
    logic         sv;
    string        tag;
    tag = op_tag(op, dst == src);
    @(negedge clk);
    req_op    = op;
    req_dst   = dst;
    req_src   = src;
    req_mem   = mem;
    req_valid = 1'b1;
    nd = exp_reg(op, model[dst], model[src], mem);
    sv = exp_is_store(op);
    sd = exp_store(op, model[src]);
    #1;
    chk("R10 ready", {127'd0, req_ready}, 128'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " st_valid"}, {127'd0, st_valid}, {127'd0, sv});
    if (sv) chk({tag, " st_data"}, {64'd0, st_data}, {64'd0, sd});
    model[dst] = nd;
    dbg_idx = dst;
    #1;
    chk({tag, " dst"}, dbg_data, model[dst]);
    if (src != dst) begin
      dbg_idx = src;
      #1;
      chk({tag, " src kept"}, dbg_data, model[src]);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cnt = 0;
    rst = 1'b1; req_valid = 1'b0; req_op = '0; req_dst = '0; req_src = '0;
    req_mem = '0; st_ready = 1'b1; dbg_idx = '0;
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 st_valid", {127'd0, st_valid}, 128'd0);
    chk("R1 req_ready", {127'd0, req_ready}, 128'd1);
    for (int r = 0; r < 16; r++) begin
      dbg_idx = 4'(r);
      #1;
      chk("R1 R13 reg clear", dbg_data, 128'd0);
    end

    // Fill with distinct patterns.
    for (int r = 0; r < 16; r++) begin
      do_op(4'd3, 4'(r), 4'(r), 64'h0123_4567_89AB_CDEF ^ (64'(r) * 64'h1111_0000_2222_0001));
      do_op(4'd1, 4'(r), 4'(r), 64'hFEDC_BA98_7654_3210 ^ (64'(r) * 64'h0003_3333_0004_4444));
    end

    // Sweep all op codes over every destination, distinct and same source.
    for (int op = 0; op < 16; op++) begin
      for (int d = 0; d < 16; d++) begin
        for (int k = 0; k < 2; k++) begin
          logic [3:0]  s;
          logic [63:0] m;
          s = (k == 0) ? 4'((d * 7 + 3) % 16) : 4'(d);
          m = 64'h1357_9BDF_2468_ACE0 ^ (64'(cnt) * 64'h0101_0203_0405_0607);
          cnt++;
          do_op(4'(op), 4'(d), s, m);
          // Refresh destination so later sweeps see non-zero upper bits.
          if (op == 8 || op == 11) begin
            do_op(4'd1, 4'(d), 4'(d), m ^ 64'hA5A5_5A5A_C3C3_3C3C);
          end
        end
      end
    end

    // Back-pressure on the store stream.
    st_ready = 1'b0;
    do_op(4'd2, 4'd4, 4'd3, 64'd0);
    @(negedge clk);
    req_op = 4'd3; req_dst = 4'd4; req_src = 4'd4;
    req_mem = 64'hDEAD_BEEF_0BAD_F00D; req_valid = 1'b1;
    #1;
    chk("R10 ready low", {127'd0, req_ready}, 128'd0);
    @(negedge clk);
    chk("R10 held valid", {127'd0, st_valid}, 128'd1);
    chk("R10 held data", {64'd0, st_data}, {64'd0, model[3][127:64]});
    dbg_idx = 4'd4;
    #1;
    chk("R10 no write", dbg_data, model[4]);
    st_ready = 1'b1;
    #1;
    chk("R10 ready back", {127'd0, req_ready}, 128'd1);
    @(negedge clk);
    req_valid = 1'b0;
    model[4] = {model[4][127:64], 64'hDEAD_BEEF_0BAD_F00D};
    chk("R11 drained", {127'd0, st_valid}, 128'd0);
    dbg_idx = 4'd4;
    #1;
    chk("R13 after release", dbg_data, model[4]);

    // Final full-file comparison through the debug port.
    for (int r = 0; r < 16; r++) begin
      dbg_idx = 4'(r);
      #1;
      chk("R13 final", dbg_data, model[r]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule